// File: doc/BRIEF.md
# Decode-Stage Branch Resolver with Fetch Redirect

This block sits at the boundary between fetch and decode in a five-stage in-order pipeline. It holds the program counter and the fetch-to-decode pipeline register, and it decides branch-if-equal instructions while they are still in decode. The decoder supplies a branch flag for the instruction now in the fetch-to-decode register. The forwarding network supplies both source operands, already bypassed, and the immediate arrives sign-extended. The block adds the scaled offset to the incremented PC stored alongside the instruction and compares the two operands for equality.

Fetch assumes every branch falls through, so the PC advances by one word each cycle. When a branch in decode proves taken, the PC loads the computed target on the next rising edge. On the same edge the fetch-to-decode register is cleared to all zeros, which the rest of the pipeline decodes as a no-operation. As a result, only the single wrong-path instruction fetched behind the branch is discarded. A branch that targets itself with equal operands keeps fetching itself, separated by one bubble, for as long as it runs.

Top module: `branch_redirect_unit`

## Requirements
- R1: While reset is active, and until the first clock edge after the synchronised release, `pc_out`, `ifid_instr` and `ifid_pc_inc` are all zero.
- R2: In a cycle with `branch_taken` low, `pc_out` advances by 4 at the next rising edge, wrapping modulo 2^AW.
- R3: In a cycle with `branch_taken` low, the next rising edge loads `ifid_instr` with `imem_instr` and `ifid_pc_inc` with `pc_out + 4`.
- R4: `branch_taken` is high exactly when `id_is_branch` is 1 and `id_opnd_a` equals `id_opnd_b`; unequal operands never take the branch.
- R5: With `id_is_branch` at 0, `branch_taken` stays low and fetch continues sequentially even when the operands are equal.
- R6: `branch_target` equals `ifid_pc_inc + (id_offset << 2)` truncated to AW bits, with negative offsets and wrap below address zero handled in two's complement.
- R7: In a cycle with `branch_taken` high, `pc_out` takes the value of `branch_target` at the next rising edge.
- R8: In a cycle with `branch_taken` high, the next rising edge clears `ifid_instr` and `ifid_pc_inc` to zero (the no-operation encoding), and this clear takes precedence over loading `imem_instr`.
- R9: A taken branch whose offset is -1 redirects fetch to its own address, and the loop repeats on each later pass without drift in the PC.
- R10: Driving `rst_n` low at any time clears `pc_out` and the fetch-to-decode register at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| imem_instr | input | IW | Instruction word fetched at `pc_out` |
| id_is_branch | input | 1 | Decoder flag: the instruction in decode is a branch-if-equal |
| id_opnd_a | input | DW | First compare operand after decode forwarding |
| id_opnd_b | input | DW | Second compare operand after decode forwarding |
| id_offset | input | DW | Sign-extended word offset of the branch |
| pc_out | output | AW | Current fetch address |
| ifid_instr | output | IW | Instruction held in the fetch-to-decode register |
| ifid_pc_inc | output | AW | Incremented PC held with that instruction |
| branch_taken | output | 1 | Branch in decode resolves taken this cycle |
| branch_target | output | AW | Computed branch target address |

## Verification
The bench builds the block with a 16-bit address path and a 32-bit data path. The narrower PC lets a backward branch taken from address zero produce a wrapped target that can be checked exactly. Because the offset is wider than the address, the truncation branch of the offset adapter is exercised. The 32-bit operands keep the equality compare at its full width.

// File: rtl/bru_pkg.sv
package bru_pkg;

  // Byte distance between consecutive instruction words.
  localparam int unsigned WORD_BYTES = 4;

  // Word offsets are scaled to bytes by this left shift.
  localparam int unsigned OFFSET_SHIFT = 2;

  // Selects where the next fetch address comes from.
  typedef enum logic {
    PC_SEQ    = 1'b0,
    PC_BRANCH = 1'b1
  } pc_sel_e;

endpackage

// File: rtl/bru_rst_sync.sv
module bru_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = (chain_q << 1) | STAGES'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_q_n = chain_q[STAGES-1];

endmodule

// File: rtl/bru_resolve.sv
module bru_resolve
  import bru_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  logic          is_branch,
  input  logic [DW-1:0] opnd_a,
  input  logic [DW-1:0] opnd_b,
  input  logic [AW-1:0] pc_inc,
  input  logic [DW-1:0] offset,
  output logic          taken,
  output logic [AW-1:0] target,
  output pc_sel_e       pc_sel
);

  logic [AW-1:0] offset_aw;
  logic [AW-1:0] offset_bytes;
  logic          operands_equal;

  // Fit the sign-extended offset to the address width.
  generate
    if (AW <= DW) begin : g_offset_trunc
      assign offset_aw = offset[AW-1:0];
    end else begin : g_offset_extend
      assign offset_aw = {{(AW-DW){offset[DW-1]}}, offset};
    end
  endgenerate

  always_comb begin
    offset_bytes   = offset_aw << OFFSET_SHIFT;
    target         = pc_inc + offset_bytes;
    operands_equal = (opnd_a == opnd_b);
    taken          = is_branch & operands_equal;
    pc_sel         = taken ? PC_BRANCH : PC_SEQ;
  end

endmodule

// File: rtl/bru_pc_reg.sv
module bru_pc_reg
  import bru_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_q_n,
  input  pc_sel_e       pc_sel,
  input  logic [AW-1:0] target,
  output logic [AW-1:0] pc_q,
  output logic [AW-1:0] pc_inc
);

  localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

  logic [AW-1:0] pc_d;

  always_comb begin
    pc_inc = pc_q + STEP;
    case (pc_sel)
      PC_BRANCH: pc_d = target;
      default:   pc_d = pc_inc;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      pc_q <= '0;
    end else begin
      pc_q <= pc_d;
    end
  end

endmodule

// File: rtl/bru_ifid_reg.sv
module bru_ifid_reg #(
  parameter int unsigned AW = 32,
  parameter int unsigned IW = 32
) (
  input  logic          clk,
  input  logic          rst_q_n,
  input  logic          flush,
  input  logic [IW-1:0] instr_in,
  input  logic [AW-1:0] pc_inc_in,
  output logic [IW-1:0] instr_q,
  output logic [AW-1:0] pc_inc_q
);

  logic [IW-1:0] instr_d;
  logic [AW-1:0] pc_inc_d;

  // Flush wins over the normal load: the slot becomes an all-zero NOP.
  always_comb begin
    if (flush) begin
      instr_d  = '0;
      pc_inc_d = '0;
    end else begin
      instr_d  = instr_in;
      pc_inc_d = pc_inc_in;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      instr_q  <= '0;
      pc_inc_q <= '0;
    end else begin
      instr_q  <= instr_d;
      pc_inc_q <= pc_inc_d;
    end
  end

endmodule

// File: rtl/branch_redirect_unit.sv
module branch_redirect_unit
  import bru_pkg::*;
#(
  parameter int unsigned AW          = 32,
  parameter int unsigned DW          = 32,
  parameter int unsigned IW          = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] imem_instr,
  input  logic          id_is_branch,
  input  logic [DW-1:0] id_opnd_a,
  input  logic [DW-1:0] id_opnd_b,
  input  logic [DW-1:0] id_offset,
  output logic [AW-1:0] pc_out,
  output logic [IW-1:0] ifid_instr,
  output logic [AW-1:0] ifid_pc_inc,
  output logic          branch_taken,
  output logic [AW-1:0] branch_target
);

  logic          rst_q_n;
  logic [AW-1:0] fetch_pc_inc;
  pc_sel_e       pc_sel;

  bru_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  bru_resolve #(
    .AW (AW),
    .DW (DW)
  ) u_resolve (
    .is_branch (id_is_branch),
    .opnd_a    (id_opnd_a),
    .opnd_b    (id_opnd_b),
    .pc_inc    (ifid_pc_inc),
    .offset    (id_offset),
    .taken     (branch_taken),
    .target    (branch_target),
    .pc_sel    (pc_sel)
  );

  bru_pc_reg #(
    .AW (AW)
  ) u_pc_reg (
    .clk     (clk),
    .rst_q_n (rst_q_n),
    .pc_sel  (pc_sel),
    .target  (branch_target),
    .pc_q    (pc_out),
    .pc_inc  (fetch_pc_inc)
  );

  bru_ifid_reg #(
    .AW (AW),
    .IW (IW)
  ) u_ifid_reg (
    .clk       (clk),
    .rst_q_n   (rst_q_n),
    .flush     (branch_taken),
    .instr_in  (imem_instr),
    .pc_inc_in (fetch_pc_inc),
    .instr_q   (ifid_instr),
    .pc_inc_q  (ifid_pc_inc)
  );

endmodule

// File: rtl/branch_redirect_unit_chk.sv
module branch_redirect_unit_chk #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32,
  parameter int unsigned IW = 32
) (
  input logic          clk,
  input logic          rst_q_n,
  input logic [IW-1:0] imem_instr,
  input logic          id_is_branch,
  input logic [DW-1:0] id_opnd_a,
  input logic [DW-1:0] id_opnd_b,
  input logic [AW-1:0] pc_out,
  input logic [IW-1:0] ifid_instr,
  input logic [AW-1:0] ifid_pc_inc,
  input logic          branch_taken,
  input logic [AW-1:0] branch_target
);

  localparam logic [AW-1:0] STEP = AW'(4);

  // R8
  flush_nop_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    branch_taken |=> (ifid_instr == '0) && (ifid_pc_inc == '0));

  // R7
  redirect_pc_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    branch_taken |=> (pc_out == $past(branch_target)));

  // R2
  seq_pc_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !branch_taken |=> (pc_out == AW'($past(pc_out) + STEP)));

  // R3
  ifid_load_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !branch_taken |=> (ifid_instr == $past(imem_instr)) &&
                      (ifid_pc_inc == AW'($past(pc_out) + STEP)));

  // R5
  no_branch_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !id_is_branch |-> !branch_taken);

  // R4
  mismatch_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (id_opnd_a != id_opnd_b) |-> !branch_taken);

endmodule

bind branch_redirect_unit branch_redirect_unit_chk #(
  .AW (AW),
  .DW (DW),
  .IW (IW)
) u_chk (
  .clk           (clk),
  .rst_q_n       (rst_q_n),
  .imem_instr    (imem_instr),
  .id_is_branch  (id_is_branch),
  .id_opnd_a     (id_opnd_a),
  .id_opnd_b     (id_opnd_b),
  .pc_out        (pc_out),
  .ifid_instr    (ifid_instr),
  .ifid_pc_inc   (ifid_pc_inc),
  .branch_taken  (branch_taken),
  .branch_target (branch_target)
);

// File: tb/branch_redirect_unit_test.sv
module branch_redirect_unit_test;

  localparam int unsigned AW = 16;
  localparam int unsigned DW = 32;
  localparam int unsigned IW = 32;
  localparam int WD_CYCLES = 20000;

  typedef struct {
    logic [AW-1:0] pc;
    logic [IW-1:0] instr;
    logic [AW-1:0] pcinc;
    string         tag;
  } item_t;

  logic          clk;
  logic          rst_n;
  logic [IW-1:0] imem_instr;
  logic          id_is_branch;
  logic [DW-1:0] id_opnd_a;
  logic [DW-1:0] id_opnd_b;
  logic [DW-1:0] id_offset;
  logic [AW-1:0] pc_out;
  logic [IW-1:0] ifid_instr;
  logic [AW-1:0] ifid_pc_inc;
  logic          branch_taken;
  logic [AW-1:0] branch_target;

  int n_chk  = 0;
  int n_fail = 0;
  item_t q[$];

  logic [AW-1:0] m_pc;
  logic [IW-1:0] m_instr;
  logic [AW-1:0] m_pcinc;

  branch_redirect_unit #(
    .AW (AW),
    .DW (DW),
    .IW (IW)
  ) uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .imem_instr    (imem_instr),
    .id_is_branch  (id_is_branch),
    .id_opnd_a     (id_opnd_a),
    .id_opnd_b     (id_opnd_b),
    .id_offset     (id_offset),
    .pc_out        (pc_out),
    .ifid_instr    (ifid_instr),
    .ifid_pc_inc   (ifid_pc_inc),
    .branch_taken  (branch_taken),
    .branch_target (branch_target)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [IW-1:0] instr_for(input logic [AW-1:0] a);
    return 32'hC0DE_0000 | IW'(a);
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Monitor: compare registered outputs against the queued expectations.
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      chk(it.tag, "pc_out", 64'(pc_out), 64'(it.pc));
      chk(it.tag, "ifid_instr", 64'(ifid_instr), 64'(it.instr));
      chk(it.tag, "ifid_pc_inc", 64'(ifid_pc_inc), 64'(it.pcinc));
    end
  end

  // Driver: drive one decode cycle, check the combinational decision,
  // then queue the state expected after the next rising edge.
  task automatic step(input logic isb, input logic [DW-1:0] a,
                      input logic [DW-1:0] b, input logic [DW-1:0] off,
                      input string tag);
    item_t it;
    logic e_taken;
    logic [AW-1:0] e_tgt;
    @(negedge clk);
    #1;
    id_is_branch = isb;
    id_opnd_a    = a;
    id_opnd_b    = b;
    id_offset    = off;
    imem_instr   = instr_for(m_pc);
    #1;
    e_taken = isb && (a == b);
    e_tgt   = AW'(m_pcinc + AW'(off * 4));
    chk(tag, "branch_taken", 64'(branch_taken), 64'(e_taken));
    chk(tag, "branch_target", 64'(branch_target), 64'(e_tgt));
    if (e_taken) begin
      m_pc    = e_tgt;
      m_instr = '0;
      m_pcinc = '0;
    end else begin
      m_instr = instr_for(m_pc);
      m_pcinc = AW'(m_pc + 4);
      m_pc    = AW'(m_pc + 4);
    end
    it.pc    = m_pc;
    it.instr = m_instr;
    it.pcinc = m_pcinc;
    it.tag   = tag;
    q.push_back(it);
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    #3;
    rst_n        = 1'b0;
    id_is_branch = 1'b0;
    #1;
    q.delete();
    chk(tag, "pc_out in reset", 64'(pc_out), 64'(0));
    chk(tag, "ifid_instr in reset", 64'(ifid_instr), 64'(0));
    chk(tag, "ifid_pc_inc in reset", 64'(ifid_pc_inc), 64'(0));
    m_pc = '0; m_instr = '0; m_pcinc = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    chk("R1", "pc_out after release", 64'(pc_out), 64'(0));
    chk("R1", "ifid_instr after release", 64'(ifid_instr), 64'(0));
  endtask

  initial begin
    rst_n        = 1'b1;
    imem_instr   = '0;
    id_is_branch = 1'b0;
    id_opnd_a    = '0;
    id_opnd_b    = '0;
    id_offset    = '0;
    m_pc = '0; m_instr = '0; m_pcinc = '0;
    #5 rst_n = 1'b0;
    do_reset("R1");

    // Backward branch from a reset-state slot wraps below zero (R6).
    step(1'b1, 32'h5, 32'h5, 32'hFFFF_FFFE, "R6");
    step(1'b0, 32'h0, 32'h1, 32'h0, "R8");

    // Sequential fetch and IF/ID loading (R2, R3).
    for (int i = 0; i < 4; i++) begin
      step(1'b0, 32'(i), 32'(i + 1), 32'(i), "R2");
    end
    step(1'b0, 32'h1234, 32'h9999, 32'h7, "R3");

    // Equal operands without a branch flag (R5).
    step(1'b0, 32'hABCD, 32'hABCD, 32'h10, "R5");

    // Branch flag with unequal operands (R4).
    step(1'b1, 32'hDEAD_BEEF, 32'hDEAD_BEEE, 32'h10, "R4");

    // Forward taken branch: redirect and flush (R7, R8).
    step(1'b1, 32'h7777_0001, 32'h7777_0001, 32'h3, "R7");
    step(1'b0, 32'h0, 32'h0, 32'h0, "R8");
    step(1'b0, 32'h1, 32'h2, 32'h0, "R3");

    // Negative offset (R6).
    step(1'b1, 32'h42, 32'h42, 32'hFFFF_FFFB, "R6");
    step(1'b0, 32'h0, 32'h1, 32'h0, "R8");
    step(1'b0, 32'h0, 32'h1, 32'h0, "R2");

    // Self loop: branch with offset -1 re-fetches itself (R9).
    for (int i = 0; i < 5; i++) begin
      step(1'b1, 32'h0, 32'h0, 32'hFFFF_FFFF, "R9");
      step(1'b0, 32'h3, 32'h4, 32'h0, "R9");
    end

    // Asynchronous reset in the middle of a run (R10).
    step(1'b0, 32'h1, 32'h2, 32'h0, "R2");
    do_reset("R10");
    step(1'b0, 32'h1, 32'h2, 32'h0, "R2");
    step(1'b0, 32'h1, 32'h2, 32'h0, "R3");
    @(negedge clk);
    #3;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule